// File: doc/BRIEF.md
# Timeslot PRBS Error-Rate Tester

This block measures bit errors over a time-division multiplexed link. A pseudo-random sequence is inserted into the outgoing timeslots that are selected for test. The incoming timeslots selected for test are compared against a sequence the receiver regenerates on its own. Mismatches are counted in a 16-bit counter that saturates. A single enable starts and stops both halves. While the transmitter is stopped, it drives constant ones into the selected output slots. The receiver therefore gives a meaningful count only after a settling period of about two frames plus the loop delay. After that period, software pulses the clear control and then reads the count.

Serial framing is outside the block. Each side gets a one-cycle strobe per bit, plus a select that says whether that bit belongs to a test timeslot. Bits in other timeslots are passed through or ignored. The transmitter advances its sequence only on test bits. The receiver synchronises itself from the first 15 test bits it sees after being enabled, and only then starts comparing.

The transmitter has two states, TX_OFF and TX_RUN. It moves from TX_OFF to TX_RUN when the enable is high at a clock edge, and back when the enable is low. The receiver has three states: RX_OFF, RX_LOAD and RX_CHECK. It goes from RX_OFF to RX_LOAD on the enable, and from RX_LOAD to RX_CHECK on the 15th loaded test bit. It returns to RX_OFF from any state when the enable is low.

Top module: `ber_test_unit`

## Requirements
- R1: When the enable has been low for a full cycle, the output bit in every test timeslot is 1.
- R2: In a non-test timeslot, the output bit equals the normal data input. A received bit whose select is 0 never changes the count.
- R3: The count stops at 0xFFFF. Further mismatches leave it at 0xFFFF, and it never wraps.
- R4: A high clear makes the count 0 at the next clock edge, and the count stays 0 while the clear is held. Counting resumes once the clear returns to 0.
- R5: On the output, the test sequence starts from an all-ones 15-bit state, so the first 15 test bits after enable are 1. The sequence obeys s[n] = s[n-14] xor s[n-15]. It advances only on a transmit strobe whose select is 1, and it restarts each time the enable is raised (the enable needs one cycle to take effect).
- R6: After enable, the receiver loads the first 15 received test bits without counting. From then on, each test bit that differs from the regenerated sequence raises the count by exactly 1 at that clock edge.
- R7: While the enable is low, received bits never change the count, and the count is held rather than cleared.
- R8: When a clear and a counted mismatch fall in the same cycle, the clear wins and the count becomes 0.
- R9: The count output holds its value in every cycle that has no counted mismatch and no clear, so reading it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ber_en | input | 1 | Shared run enable for transmitter and receiver |
| cnt_clr | input | 1 | Error count clear, active high |
| tx_strobe | input | 1 | One outgoing bit is being emitted this cycle |
| tx_sel | input | 1 | Current outgoing bit belongs to a test timeslot |
| tx_din | input | 1 | Normal outgoing data bit |
| tx_dout | output | 1 | Outgoing bit after test insertion |
| rx_strobe | input | 1 | One incoming bit is presented this cycle |
| rx_sel | input | 1 | Current incoming bit belongs to a test timeslot |
| rx_din | input | 1 | Incoming data bit |
| err_count | output | 16 | Saturating mismatch count |

## Verification
Two functions can land in the same cycle. The clear can coincide with a counted mismatch, and a mismatch can arrive while the count is already saturated. The random phase injects errors into the loop-back stream and pulses the clear at random, so the two overlap now and then. A directed step drives a clear together with a forced mismatch while the count sits at 0xFFFF. In each case the bench's own count model expects the clear to win (0) and saturation to hold (0xFFFF), and the read value is compared one clock after the event.

// File: rtl/ber_pkg.sv
package ber_pkg;

    typedef enum logic {
        TX_OFF,
        TX_RUN
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_OFF,
        RX_LOAD,
        RX_CHECK
    } rx_state_t;

    // Feedback bit of a two-tap Fibonacci register, oldest bit at MSB.
    function automatic logic prbs_fb(input logic [31:0] q, input int unsigned w,
                                     input int unsigned tap);
        return q[w-1] ^ q[tap-1];
    endfunction

endpackage

// File: rtl/ber_prbs_tx.sv
module ber_prbs_tx
    import ber_pkg::*;
#(
    parameter int unsigned PRBS_W = 15,
    parameter int unsigned PRBS_TAP = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    input  logic sel,
    input  logic din,
    output logic dout
);
    localparam logic [PRBS_W-1:0] SEED = {PRBS_W{1'b1}};

    tx_state_t       state_q, state_d;
    logic [PRBS_W-1:0] lfsr_q, lfsr_d;
    logic            running;
    logic            fb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
            lfsr_q  <= SEED;
        end else begin
            state_q <= state_d;
            lfsr_q  <= lfsr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_OFF: if (en)  state_d = TX_RUN;
            TX_RUN: if (!en) state_d = TX_OFF;
            default: state_d = TX_OFF;
        endcase
    end

    always_comb begin
        running = (state_q == TX_RUN) && en;
        fb      = prbs_fb(32'(lfsr_q), PRBS_W, PRBS_TAP);
        lfsr_d  = lfsr_q;
        if (!running) begin
            lfsr_d = SEED;
        end else if (strobe && sel) begin
            lfsr_d = {lfsr_q[PRBS_W-2:0], fb};
        end
    end

    always_comb begin
        if (!sel) begin
            dout = din;
        end else if (running) begin
            dout = lfsr_q[PRBS_W-1];
        end else begin
            dout = 1'b1;
        end
    end

endmodule

// File: rtl/ber_rx_check.sv
module ber_rx_check
    import ber_pkg::*;
#(
    parameter int unsigned PRBS_W = 15,
    parameter int unsigned PRBS_TAP = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    input  logic sel,
    input  logic din,
    output logic err
);
    localparam int unsigned LCNT_W = $clog2(PRBS_W + 1);
    localparam logic [LCNT_W-1:0] LAST = LCNT_W'(PRBS_W - 1);

    rx_state_t         state_q, state_d;
    logic [PRBS_W-1:0] sr_q, sr_d;
    logic [LCNT_W-1:0] lcnt_q, lcnt_d;
    logic              take;
    logic              exp_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_OFF;
            sr_q    <= '0;
            lcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            sr_q    <= sr_d;
            lcnt_q  <= lcnt_d;
        end
    end

    always_comb begin
        take    = strobe && sel && en;
        exp_bit = prbs_fb(32'(sr_q), PRBS_W, PRBS_TAP);
    end

    always_comb begin
        state_d = state_q;
        sr_d    = sr_q;
        lcnt_d  = lcnt_q;
        unique case (state_q)
            RX_OFF: begin
                lcnt_d = '0;
                if (en) state_d = RX_LOAD;
            end
            RX_LOAD: begin
                if (!en) begin
                    state_d = RX_OFF;
                end else if (take) begin
                    sr_d = {sr_q[PRBS_W-2:0], din};
                    if (lcnt_q == LAST) begin
                        lcnt_d  = '0;
                        state_d = RX_CHECK;
                    end else begin
                        lcnt_d = lcnt_q + 1'b1;
                    end
                end
            end
            RX_CHECK: begin
                if (!en) begin
                    state_d = RX_OFF;
                end else if (take) begin
                    sr_d = {sr_q[PRBS_W-2:0], exp_bit};
                end
            end
            default: state_d = RX_OFF;
        endcase
    end

    always_comb begin
        err = (state_q == RX_CHECK) && take && (din != exp_bit);
    end

endmodule

// File: rtl/ber_err_counter.sv
module ber_err_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/ber_test_unit.sv
module ber_test_unit #(
    parameter int unsigned PRBS_W = 15,
    parameter int unsigned PRBS_TAP = 14,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ber_en,
    input  logic             cnt_clr,
    input  logic             tx_strobe,
    input  logic             tx_sel,
    input  logic             tx_din,
    output logic             tx_dout,
    input  logic             rx_strobe,
    input  logic             rx_sel,
    input  logic             rx_din,
    output logic [CNT_W-1:0] err_count
);
    logic rx_err;

    ber_prbs_tx #(.PRBS_W(PRBS_W), .PRBS_TAP(PRBS_TAP)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(ber_en), .strobe(tx_strobe),
        .sel(tx_sel), .din(tx_din), .dout(tx_dout)
    );

    ber_rx_check #(.PRBS_W(PRBS_W), .PRBS_TAP(PRBS_TAP)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(ber_en), .strobe(rx_strobe),
        .sel(rx_sel), .din(rx_din), .err(rx_err)
    );

    ber_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(rx_err),
        .count(err_count)
    );

endmodule

// File: rtl/ber_test_unit_chk.sv
module ber_test_unit_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ber_en,
    input logic             cnt_clr,
    input logic             tx_strobe,
    input logic             tx_sel,
    input logic             tx_din,
    input logic             tx_dout,
    input logic             rx_strobe,
    input logic             rx_sel,
    input logic             rx_din,
    input logic [CNT_W-1:0] err_count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    p_idle_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ber_en && !$past(ber_en) && tx_sel) |-> tx_dout);

    p_nontest_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_sel && !cnt_clr) |=> $stable(err_count));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == TOP && !cnt_clr) |=> (err_count == TOP));

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (err_count == '0));

    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (err_count == $past(err_count) ||
                      err_count == $past(err_count) + 1'b1));

    p_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ber_en && !cnt_clr) |=> $stable(err_count));

    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_strobe && !cnt_clr) |=> $stable(err_count));

endmodule

bind ber_test_unit ber_test_unit_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_ber_test_unit.sv
module sim_ber_test_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ber_en = 1'b0, cnt_clr = 1'b0;
    logic tx_strobe = 1'b0, tx_sel = 1'b0, tx_din = 1'b0;
    logic rx_strobe = 1'b0, rx_sel = 1'b0, rx_din = 1'b0;
    logic tx_dout;
    logic [15:0] err_count;

    int checks = 0, fails = 0, cycles = 0;
    logic [14:0] ref_tx, ref_rx;
    logic        tx_live;
    int          rx_loaded;
    logic [15:0] exp_cnt;
    int unsigned seed_dummy;

    ber_test_unit u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [14:0] step(input logic [14:0] q);
        return {q[13:0], q[14] ^ q[13]};
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
            finish_up();
        end
    end

    task automatic idle_in();
        tx_strobe = 0; tx_sel = 0; rx_strobe = 0; rx_sel = 0; cnt_clr = 0;
    endtask

    task automatic start_run();
        @(negedge clk);
        idle_in();
        ber_en = 1;
        ref_tx = '1; ref_rx = '1; rx_loaded = 0; tx_live = 0;
        @(negedge clk);
        tx_live = 1;
    endtask

    // One bench cycle: drive at negedge, check tx combinationally, update model,
    // check count at next negedge.
    task automatic cycle(input logic ts, input logic tsel, input logic tdin,
                         input logic rs, input logic rsel, input logic inj,
                         input logic clr, input string req);
        logic bit_ok;
        tx_strobe = ts; tx_sel = tsel; tx_din = tdin;
        rx_strobe = rs; rx_sel = rsel; cnt_clr = clr;
        bit_ok = (rx_loaded >= 15) && inj;
        rx_din = rsel ? (ref_rx[14] ^ bit_ok) : $urandom_range(0, 1);
        #1;
        if (tsel) chk(tx_live && ber_en ? "R5" : "R1", tx_dout,
                      (tx_live && ber_en) ? ref_tx[14] : 1'b1);
        else      chk("R2", tx_dout, tdin);
        if (ts && tsel && tx_live && ber_en) ref_tx = step(ref_tx);
        if (clr) exp_cnt = 0;
        else if (ber_en && rs && rsel && bit_ok && exp_cnt != 16'hFFFF) exp_cnt++;
        if (ber_en && rs && rsel) begin
            ref_rx = step(ref_rx);
            rx_loaded++;
        end
        @(negedge clk);
        chk(req, err_count, exp_cnt);
    endtask

    initial begin
        seed_dummy = $urandom(32'd20240611);
        exp_cnt = 0; ref_tx = '1; ref_rx = '1; rx_loaded = 0; tx_live = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R4", err_count, 0);
        tx_sel = 1; #1;
        chk("R1", tx_dout, 1);
        tx_sel = 0;

        // R1/R7: disabled, errors ignored, test slots drive ones
        for (int i = 0; i < 40; i++)
            cycle(1, 1, 0, 1, 1, 1, 0, "R7");

        // random rounds: R2 R5 R6 R8
        for (int r = 0; r < 3; r++) begin
            start_run();
            for (int i = 0; i < 3000; i++)
                cycle($urandom_range(0, 1), $urandom_range(0, 2) != 0,
                      $urandom_range(0, 1), $urandom_range(0, 1),
                      $urandom_range(0, 2) != 0, $urandom_range(0, 7) == 0,
                      $urandom_range(0, 199) == 0, "R6");
            // R2: non-test received bits with errors: never counted
            for (int i = 0; i < 30; i++)
                cycle(0, 0, 1, 1, 0, 1, 0, "R2");
            // R9: quiet cycles hold count
            for (int i = 0; i < 20; i++)
                cycle(0, 0, 0, 0, 0, 0, 0, "R9");
            // R7: drop enable, count held
            @(negedge clk); ber_en = 0; tx_live = 0;
            for (int i = 0; i < 20; i++)
                cycle(1, 1, 0, 1, 1, 1, 0, "R7");
        end

        // R4: clear, then resume
        start_run();
        cycle(0, 0, 0, 0, 0, 0, 1, "R4");
        for (int i = 0; i < 15; i++) cycle(0, 0, 0, 1, 1, 0, 0, "R6");
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 1, 1, 1, 1, "R4");
        cycle(0, 0, 0, 1, 1, 1, 0, "R4");
        chk("R4", err_count, 1);

        // R3: saturate with every test bit wrong
        for (int i = 0; i < 65540; i++) cycle(0, 0, 0, 1, 1, 1, 0, "R3");
        chk("R3", err_count, 16'hFFFF);
        for (int i = 0; i < 5; i++) cycle(0, 0, 0, 1, 1, 1, 0, "R3");
        chk("R3", err_count, 16'hFFFF);

        // R8: clear and mismatch together
        cycle(0, 0, 0, 1, 1, 1, 1, "R8");
        chk("R8", err_count, 0);
        cycle(0, 0, 0, 1, 1, 1, 0, "R6");
        chk("R6", err_count, 1);

        finish_up();
    end
endmodule